// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block takes one asynchronous serial line and turns each frame on it into a parallel word in a single holding register. A frame is one low start bit, then seven or eight data bits with the least significant bit first, then an optional parity bit, then one high stop bit. Bit timing comes from an oversampling tick enable that the block does not generate. Each bit lasts `OVERSAMPLE` ticks. The line passes through a reset-to-high synchronizer before it is used.

On the stop sample the assembled word moves into the holding register. A full flag is raised and a one-clock interrupt pulse is issued. The holding register has only one entry. When a new word arrives before the previous one has been read, the new word replaces it and an overrun flag is set, and reception continues. Start, parity and frame error flags are loaded only when a word moves into the register, so they always describe the word currently held. A read strobe releases the register. A write strobe clears the overrun flag.

Top module: `serial_rx_unit`

## Requirements
- R1: `rx_busy` rises after a start is detected and stays high until the stop sample or a rejected start. A start is detected only after the line has been seen high while idle and is then sampled low.
- R2: At the stop sample the received bits move into `rx_data`, first bit in bit 0. When `cfg_len7`=1 the frame carries seven data bits and `rx_data[7]` reads 0.
- R3: Every transfer sets `rx_full` and produces a `rx_irq` pulse exactly one clock wide. This includes a transfer that causes an overrun.
- R4: A `rd_data` strobe clears `rx_full` on the next clock, unless a transfer happens in the same clock.
- R5: A transfer while `rx_full`=1, with no read in the same clock, sets `err_overrun`, and the new word replaces the old one.
- R6: A `wr_status` strobe clears `err_overrun`. It leaves `rx_full`, `rx_data` and the other error flags unchanged.
- R7: With `cfg_par_en`=1 a parity bit follows the data bits. With `cfg_par_odd`=0 the expected parity bit equals the XOR of the data bits; with `cfg_par_odd`=1 it is that XOR inverted. A mismatch sets `err_parity` at transfer. With `cfg_par_en`=0 no parity bit is received and `err_parity` is 0 at transfer.
- R8: A start is accepted only if the line is still low OVERSAMPLE/2 ticks after detection. Otherwise the receiver drops `rx_busy`, makes no transfer, and reports `err_start`=1 at the next transfer. The transfer after that reports 0.
- R9: A low stop sample sets `err_frame` at transfer. The word is still transferred.
- R10: `err_start`, `err_parity` and `err_frame` change only at a transfer.
- R11: The receiver advances only on clocks with `os_tick`=1. Each data bit lasts OVERSAMPLE ticks, however many clocks separate the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick enable |
| rx_in | input | 1 | Serial input line, idle high |
| cfg_len7 | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| rd_data | input | 1 | Read strobe for the data register |
| wr_status | input | 1 | Write strobe for the status register |
| rx_data | output | DATA_W | Received word |
| rx_busy | output | 1 | Frame in progress |
| rx_full | output | 1 | Unread word held |
| err_overrun | output | 1 | Word overwritten before being read |
| err_start | output | 1 | Rejected start since the previous transfer |
| err_parity | output | 1 | Parity mismatch in the held word |
| err_frame | output | 1 | Stop bit sampled low for the held word |
| rx_irq | output | 1 | One-clock pulse on each transfer |

## Verification
Frames are sent with asymmetric bytes in both word lengths, so that a reversed bit order or a missing top bit shows up in the data. Parity is tried four ways: even and correct, odd and corrupted, deliberately wrong, and disabled with a wrong-looking bit pattern. These separate the parity sense from the enable. Two unread frames in a row separate overwrite and overrun from plain delivery. A short low glitch, a low stop bit and a slower tick rate separate start qualification, frame checking and tick gating from ordinary reception.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("rx_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= '1;
            end else begin
               ff[0] <= d;
               for (int s = 1; s < STAGES; s++) ff[s] <= ff[s-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_framer.sv
module rx_framer
   import serial_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              len7,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              busy_o,
   output logic              xfer_o,
   output logic [DATA_W-1:0] word_o,
   output logic              perr_o,
   output logic              ferr_o,
   output logic              serr_o
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("rx_framer: OVERSAMPLE must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("rx_framer: DATA_W must be at least 2");
      end
   endgenerate

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              serr_pend;
   logic              armed;
   logic [IDX_W-1:0]  last_idx;
   logic              at_mid;
   logic              at_end;

   assign last_idx = len7 ? LAST_SHORT : LAST_LONG;
   assign at_mid   = (cnt == HALF_M1);
   assign at_end   = (cnt == FULL_M1);

   assign busy_o = (state != RX_IDLE);
   assign xfer_o = (state == RX_STOP) && tick && at_end;
   assign word_o = shreg;
   assign ferr_o = !rx;
   assign serr_o = serr_pend;
   assign perr_o = par_en & (par_bit ^ (^shreg) ^ par_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         par_bit   <= 1'b0;
         serr_pend <= 1'b0;
         armed     <= 1'b0;
      end else if (tick) begin
         unique case (state)
            RX_IDLE: begin
               if (rx) begin
                  armed <= 1'b1;
               end else if (armed) begin
                  state   <= RX_START;
                  armed   <= 1'b0;
                  cnt     <= '0;
                  idx     <= '0;
                  shreg   <= '0;
                  par_bit <= 1'b0;
               end
            end
            RX_START: begin
               if (at_mid) begin
                  cnt <= '0;
                  if (!rx) begin
                     state <= RX_DATA;
                  end else begin
                     state     <= RX_IDLE;
                     serr_pend <= 1'b1;
                     armed     <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (at_end) begin
                  cnt        <= '0;
                  shreg[idx] <= rx;
                  if (idx == last_idx) state <= par_en ? RX_PAR : RX_STOP;
                  else                 idx   <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_PAR: begin
               if (at_end) begin
                  cnt     <= '0;
                  par_bit <= rx;
                  state   <= RX_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (at_end) begin
                  cnt       <= '0;
                  state     <= RX_IDLE;
                  serr_pend <= 1'b0;
                  armed     <= rx;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R11: nothing moves between ticks
   assert_notick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(state) && $stable(cnt)));
   // R8: a rejected start never leads straight to a transfer
   assert_serr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(serr_pend) |-> (state == RX_IDLE));
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer,
   input  logic [DATA_W-1:0] word,
   input  logic              perr,
   input  logic              ferr,
   input  logic              serr,
   input  logic              rd,
   input  logic              wr,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output logic              ovr_q,
   output logic              serr_q,
   output logic              perr_q,
   output logic              ferr_q,
   output logic              irq_q
);
   logic ovr_event;
   assign ovr_event = xfer & full_q & ~rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         serr_q <= 1'b0;
         perr_q <= 1'b0;
         ferr_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= xfer;
         ovr_q <= (ovr_q & ~wr) | ovr_event;
         if (xfer) begin
            data_q <= word;
            full_q <= 1'b1;
            serr_q <= serr;
            perr_q <= perr;
            ferr_q <= ferr;
         end else if (rd) begin
            full_q <= 1'b0;
         end
      end
   end

   assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   assert_irq_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> full_q);
   assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !xfer) |=> !full_q);
   assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && full_q && !rd) |=> ovr_q);
   assert_wr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !(xfer && full_q && !rd)) |=> !ovr_q);
   assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> ($stable(perr_q) && $stable(ferr_q) && $stable(serr_q)));
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_in,
   input  logic              cfg_len7,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              rd_data,
   input  logic              wr_status,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_busy,
   output logic              rx_full,
   output logic              err_overrun,
   output logic              err_start,
   output logic              err_parity,
   output logic              err_frame,
   output logic              rx_irq
);
   logic              rx_s;
   logic              xfer;
   logic [DATA_W-1:0] word;
   logic              perr;
   logic              ferr;
   logic              serr;

   rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_in),
      .q     (rx_s)
   );

   rx_framer #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) i_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (os_tick),
      .rx      (rx_s),
      .len7    (cfg_len7),
      .par_en  (cfg_par_en),
      .par_odd (cfg_par_odd),
      .busy_o  (rx_busy),
      .xfer_o  (xfer),
      .word_o  (word),
      .perr_o  (perr),
      .ferr_o  (ferr),
      .serr_o  (serr)
   );

   rx_holding #(.DATA_W(DATA_W)) i_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .xfer   (xfer),
      .word   (word),
      .perr   (perr),
      .ferr   (ferr),
      .serr   (serr),
      .rd     (rd_data),
      .wr     (wr_status),
      .data_q (rx_data),
      .full_q (rx_full),
      .ovr_q  (err_overrun),
      .serr_q (err_start),
      .perr_q (err_parity),
      .ferr_q (err_frame),
      .irq_q  (rx_irq)
   );

   assert_irq_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(rx_busy));
   assert_nopar_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !cfg_par_en) |=> !err_parity);
endmodule

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
   localparam int CLK_P = 10;
   localparam int OS    = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic       cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic       rd_data = 1'b0, wr_status = 1'b0;
   logic [7:0] rx_data;
   logic       rx_busy, rx_full, err_overrun, err_start, err_parity, err_frame, rx_irq;

   int n_chk = 0, n_fail = 0;
   int tick_div = 1, tick_cnt = 0;
   int irq_cnt = 0, irq_wide = 0;
   bit irq_prev = 0, busy_seen = 0, done = 0;

   always #(CLK_P/2) clk = ~clk;

   serial_rx_unit i_serial_rx_unit (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
      .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .rd_data(rd_data), .wr_status(wr_status), .rx_data(rx_data),
      .rx_busy(rx_busy), .rx_full(rx_full), .err_overrun(err_overrun),
      .err_start(err_start), .err_parity(err_parity), .err_frame(err_frame),
      .rx_irq(rx_irq)
   );

   always @(negedge clk) begin
      if (tick_cnt >= tick_div - 1) begin
         tick_cnt = 0;
         os_tick <= 1'b1;
      end else begin
         tick_cnt = tick_cnt + 1;
         os_tick <= 1'b0;
      end
      if (rx_irq) irq_cnt = irq_cnt + 1;
      if (rx_irq && irq_prev) irq_wide = irq_wide + 1;
      irq_prev = rx_irq;
      if (rx_busy) busy_seen = 1;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bit_wait();
      repeat (OS * tick_div) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit flip_par,
                             input bit stop_val);
      bit p;
      p = cfg_par_odd ^ flip_par;
      @(negedge clk);
      rx_in = 1'b0;
      bit_wait();
      for (int i = 0; i < nb; i++) begin
         rx_in = d[i];
         p ^= d[i];
         bit_wait();
      end
      if (cfg_par_en) begin
         rx_in = p;
         bit_wait();
      end
      rx_in = stop_val;
      bit_wait();
      rx_in = 1'b1;
      bit_wait();
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_data = 1'b1;
      @(negedge clk); rd_data = 1'b0;
   endtask

   task automatic pulse_wr();
      @(negedge clk); wr_status = 1'b1;
      @(negedge clk); wr_status = 1'b0;
   endtask

   task automatic t_reset();
      check("R2 reset data", rx_data, 0);
      check("R3 reset full", rx_full, 0);
      check("R1 reset busy", rx_busy, 0);
      check("R5 reset overrun", err_overrun, 0);
      check("R10 reset errors", {err_start, err_parity, err_frame}, 0);
   endtask

   task automatic t_basic8();
      int i0 = irq_cnt;
      busy_seen = 0;
      cfg_len7 = 0; cfg_par_en = 0;
      send_frame(8'hA5 ^ 8'h6C, 8, 0, 1);
      check("R1 busy seen during frame", busy_seen, 1);
      check("R1 busy low after frame", rx_busy, 0);
      check("R2 data 8-bit", rx_data, 8'hC9);
      check("R3 full set", rx_full, 1);
      check("R3 one irq", irq_cnt - i0, 1);
      check("R9 no frame error", err_frame, 0);
      pulse_rd();
      @(negedge clk);
      check("R4 read clears full", rx_full, 0);
      check("R4 read keeps data", rx_data, 8'hC9);
   endtask

   task automatic t_len7_even();
      cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 0;
      send_frame(8'h35, 7, 0, 1);
      check("R2 data 7-bit top bit zero", rx_data, 8'h35);
      check("R7 even parity ok", err_parity, 0);
      pulse_rd();
      send_frame(8'hB3, 7, 0, 1);
      check("R2 7-bit drops bit 7", rx_data, 8'h33);
      pulse_rd();
   endtask

   task automatic t_odd_bad();
      cfg_len7 = 0; cfg_par_en = 1; cfg_par_odd = 1;
      send_frame(8'h81, 8, 0, 1);
      check("R7 odd parity ok", err_parity, 0);
      pulse_rd();
      send_frame(8'h17, 8, 1, 1);
      check("R7 odd parity mismatch", err_parity, 1);
      check("R7 data with bad parity", rx_data, 8'h17);
      pulse_rd();
      pulse_wr();
      @(negedge clk);
      check("R10 parity error held after read and write", err_parity, 1);
      cfg_par_odd = 0;
      send_frame(8'h17, 8, 1, 1);
      check("R7 even parity mismatch", err_parity, 1);
      pulse_rd();
   endtask

   task automatic t_nopar();
      cfg_par_en = 0; cfg_par_odd = 1;
      send_frame(8'hFE, 8, 1, 1);
      check("R7 parity disabled flag zero", err_parity, 0);
      check("R7 parity disabled data", rx_data, 8'hFE);
      pulse_rd();
   endtask

   task automatic t_overrun();
      int i0 = irq_cnt;
      send_frame(8'h11, 8, 0, 1);
      check("R5 no overrun on first", err_overrun, 0);
      send_frame(8'h2E, 8, 0, 1);
      check("R5 overrun set", err_overrun, 1);
      check("R5 newer word kept", rx_data, 8'h2E);
      check("R3 irq on overrun transfer", irq_cnt - i0, 2);
      pulse_wr();
      @(negedge clk);
      check("R6 write clears overrun", err_overrun, 0);
      check("R6 write keeps full", rx_full, 1);
      check("R6 write keeps data", rx_data, 8'h2E);
      pulse_rd();
   endtask

   task automatic t_frame();
      send_frame(8'h5A, 8, 0, 0);
      check("R9 frame error set", err_frame, 1);
      check("R9 word still transferred", rx_data, 8'h5A);
      check("R3 full after frame error", rx_full, 1);
      pulse_rd();
      send_frame(8'h3C, 8, 0, 1);
      check("R9 frame error cleared by good frame", err_frame, 0);
      pulse_rd();
   endtask

   task automatic t_false_start();
      int i0 = irq_cnt;
      busy_seen = 0;
      @(negedge clk); rx_in = 1'b0;
      repeat (4) @(negedge clk);
      rx_in = 1'b1;
      repeat (3 * OS) @(negedge clk);
      check("R8 busy raised by glitch", busy_seen, 1);
      check("R8 busy dropped after glitch", rx_busy, 0);
      check("R8 no transfer from glitch", irq_cnt - i0, 0);
      check("R10 start error not yet shown", err_start, 0);
      send_frame(8'h96, 8, 0, 1);
      check("R8 start error at next transfer", err_start, 1);
      check("R8 data after glitch", rx_data, 8'h96);
      pulse_rd();
      send_frame(8'h69, 8, 0, 1);
      check("R8 start error cleared", err_start, 0);
      pulse_rd();
   endtask

   task automatic t_slow_tick();
      int i0 = irq_cnt;
      tick_div = 3;
      send_frame(8'h4D, 8, 0, 1);
      check("R11 slow tick data", rx_data, 8'h4D);
      check("R11 slow tick one irq", irq_cnt - i0, 1);
      tick_div = 1;
      pulse_rd();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      repeat (OS) @(negedge clk);
      t_basic8();
      t_len7_even();
      t_odd_bad();
      t_nopar();
      t_overrun();
      t_frame();
      t_false_start();
      t_slow_tick();
      check("R3 irq never wider than one clock", irq_wide, 0);
      done = 1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule